// File: doc/BRIEF.md
# Timer Interrupt Flag and Mask Controller

This block gathers event pulses from up to 32 timer channels into a bank of sticky flag bits and pairs every flag with a mask bit. A source is pending while its flag is set and its mask bit is clear. Pending sources are merged onto a few level-sensitive parent interrupt lines toward the system interrupt controller. A build-time variant fixes which sources share a line.

Software reaches the block over a simple synchronous register bus. It can read back both the flags and the mask. It never writes either of them directly. Separate write-one registers set mask bits, clear mask bits and clear flags, so each write touches only the sources whose data bits are 1. A channel can therefore be serviced without a read-modify-write that might race with another channel.

Top module: `tirq_ctrl`

## Requirements
- R1: On reset, every mask bit becomes 1 and every flag becomes 0. All parent lines and the read data bus go to 0.
- R2: A one-cycle pulse on an event input sets that source's flag at the next clock edge. The flag then stays 1 until software clears it.
- R3: A write to byte offset 0x04 clears the flags whose data bits are 1. Flags whose data bits are 0 keep their value.
- R4: If an event pulse and a flag-clear write hit the same bit in the same cycle, the flag ends up 1.
- R5: A write to offset 0x0C sets the mask bits whose data bits are 1, which disables those sources. Other mask bits keep their value.
- R6: A write to offset 0x10 clears the mask bits whose data bits are 1, which enables those sources. Other mask bits keep their value.
- R7: A read of offset 0x00 returns the flags and a read of offset 0x08 returns the mask. The data appears on the read bus one cycle after the read strobe and holds the state from before that clock edge. Reads of 0x04, 0x0C, 0x10 or any other offset return 0. Writes to other offsets change nothing.
- R8: A source is pending when its flag is 1 and its mask bit is 0. Each parent line is the OR of the pending bits in its group, registered, so it follows the flag and mask state one clock later.
- R9: With VARIANT=0, line 0 carries source 0, line 1 carries source 1, and line 2 carries every other source.
- R10: With VARIANT=1, line 0 carries source 5, line 1 carries every other source, and line 2 is held at 0.
- R11: The lines are level outputs. A line stays high for as long as a pending source remains in its group, and falls only when that source's flag is cleared or its mask bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_evt_i | input | NUM_SRC | One-cycle event pulse per source |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | ADDR_W | Byte offset of the access |
| bus_wdata_i | input | NUM_SRC | Write data, one bit per source |
| bus_rdata_o | output | NUM_SRC | Registered read data |
| irq_o | output | 3 | Level-sensitive parent interrupt lines |

## Verification
On every cycle the assertions check the bit-level effect of each write-one register, the rule that an event beats a clear, the reset values, the zero returned for write-only offsets, and that no line rises without a pending source one cycle earlier. Only the bench scenarios can show the routing of each variant, which requires specific sources to land on specific lines. They also show that a line holds its level over many cycles and then drops on a clear or a mask, and that a read returns the state from before the edge that updates it.

// File: rtl/tirq_pkg.sv
package tirq_pkg;
  // Register byte offsets
  localparam int OFS_FLAG     = 'h00;
  localparam int OFS_FLAG_CLR = 'h04;
  localparam int OFS_MASK     = 'h08;
  localparam int OFS_MASK_SET = 'h0C;
  localparam int OFS_MASK_CLR = 'h10;

  // Build variants for the parent line grouping
  localparam int VARIANT_TWO_SOLO  = 0;
  localparam int VARIANT_ONE_SOLO  = 1;

  localparam int NUM_LINES = 3;

  // Sources that own a private line
  localparam int SOLO_A0 = 0;
  localparam int SOLO_A1 = 1;
  localparam int SOLO_B  = 5;

  typedef struct packed {
    logic flag_clr;
    logic mask_set;
    logic mask_clr;
  } wr_sel_t;
endpackage

// File: rtl/tirq_regbus.sv
module tirq_regbus #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] flags,
  input  logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] flag_clr,
  output logic [DATA_W-1:0] mask_set,
  output logic [DATA_W-1:0] mask_clr,
  output logic [DATA_W-1:0] rdata
);
  import tirq_pkg::*;

  localparam logic [ADDR_W-1:0] A_FLAG  = ADDR_W'(OFS_FLAG);
  localparam logic [ADDR_W-1:0] A_FCLR  = ADDR_W'(OFS_FLAG_CLR);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_MSET  = ADDR_W'(OFS_MASK_SET);
  localparam logic [ADDR_W-1:0] A_MCLR  = ADDR_W'(OFS_MASK_CLR);

  wr_sel_t sel;

  always_comb begin
    sel.flag_clr = wr_en && (addr == A_FCLR);
    sel.mask_set = wr_en && (addr == A_MSET);
    sel.mask_clr = wr_en && (addr == A_MCLR);
  end

  assign flag_clr = sel.flag_clr ? wdata : '0;
  assign mask_set = sel.mask_set ? wdata : '0;
  assign mask_clr = sel.mask_clr ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (addr)
        A_FLAG:  rdata <= flags;
        A_MASK:  rdata <= mask;
        default: rdata <= '0;
      endcase
    end
  end

  // R7
  wo_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr != A_FLAG && addr != A_MASK) |=> (rdata == '0));

  // R7
  flag_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_FLAG) |=> (rdata == $past(flags)));
endmodule

// File: rtl/tirq_flag_bank.sv
module tirq_flag_bank #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_evt,
  input  logic [NUM_SRC-1:0] flag_clr,
  input  logic [NUM_SRC-1:0] mask_set,
  input  logic [NUM_SRC-1:0] mask_clr,
  output logic [NUM_SRC-1:0] flags,
  output logic [NUM_SRC-1:0] mask,
  output logic [NUM_SRC-1:0] pend
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        flags[i] <= 1'b0;
        mask[i]  <= 1'b1;
      end else begin
        // an event in the same cycle overrides a clear
        flags[i] <= src_evt[i] | (flags[i] & ~flag_clr[i]);
        mask[i]  <= (mask[i] | mask_set[i]) & ~mask_clr[i];
      end
    end
  end

  assign pend = flags & ~mask;

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (flags == '0 && mask == '1));

  // R3
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (|flag_clr) |=> ((flags & $past(flag_clr & ~src_evt)) == '0));

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (|src_evt) |=> ((flags & $past(src_evt)) == $past(src_evt)));

  // R5
  mask_set_chk: assert property (@(posedge clk) disable iff (rst)
    (|mask_set) |=> ((mask & $past(mask_set)) == $past(mask_set)));

  // R6
  mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (|mask_clr) |=> ((mask & $past(mask_clr)) == '0));
endmodule

// File: rtl/tirq_line_router.sv
module tirq_line_router #(
  parameter int NUM_SRC = 32,
  parameter int VARIANT = 0
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_SRC-1:0]             pend,
  output logic [tirq_pkg::NUM_LINES-1:0] irq
);
  import tirq_pkg::*;

  function automatic logic [NUM_SRC-1:0] group_of(input int line);
    logic [NUM_SRC-1:0] g;
    g = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (VARIANT == VARIANT_ONE_SOLO) begin
        if (line == 0) g[s] = (s == SOLO_B);
        if (line == 1) g[s] = (s != SOLO_B);
      end else begin
        if (line == 0) g[s] = (s == SOLO_A0);
        if (line == 1) g[s] = (s == SOLO_A1);
        if (line == 2) g[s] = (s != SOLO_A0) && (s != SOLO_A1);
      end
    end
    return g;
  endfunction

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    localparam logic [NUM_SRC-1:0] GRP = group_of(l);
    if (GRP == '0) begin : g_unused
      assign irq[l] = 1'b0;
    end else begin : g_used
      always_ff @(posedge clk) begin
        if (rst) irq[l] <= 1'b0;
        else     irq[l] <= |(pend & GRP);
      end
    end
  end

  // R8
  no_spurious_line_chk: assert property (@(posedge clk) disable iff (rst)
    (|irq) |-> $past(|pend));
endmodule

// File: rtl/tirq_ctrl.sv
module tirq_ctrl #(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 5,
  parameter int VARIANT = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_evt_i,
  input  logic               bus_wr_i,
  input  logic               bus_rd_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [NUM_SRC-1:0] bus_wdata_i,
  output logic [NUM_SRC-1:0] bus_rdata_o,
  output logic [2:0]         irq_o
);
  logic [NUM_SRC-1:0] flags, mask, pend;
  logic [NUM_SRC-1:0] flag_clr, mask_set, mask_clr;

  tirq_regbus #(.ADDR_W(ADDR_W), .DATA_W(NUM_SRC)) u_regbus (
    .clk(clk), .rst(rst),
    .wr_en(bus_wr_i), .rd_en(bus_rd_i), .addr(bus_addr_i), .wdata(bus_wdata_i),
    .flags(flags), .mask(mask),
    .flag_clr(flag_clr), .mask_set(mask_set), .mask_clr(mask_clr),
    .rdata(bus_rdata_o)
  );

  tirq_flag_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk(clk), .rst(rst), .src_evt(src_evt_i),
    .flag_clr(flag_clr), .mask_set(mask_set), .mask_clr(mask_clr),
    .flags(flags), .mask(mask), .pend(pend)
  );

  tirq_line_router #(.NUM_SRC(NUM_SRC), .VARIANT(VARIANT)) u_router (
    .clk(clk), .rst(rst), .pend(pend), .irq(irq_o)
  );

  // R1
  reset_out_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq_o == 3'b000 && bus_rdata_o == '0));
endmodule

// File: tb/tirq_ctrl_bench.sv
module tirq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  src = '0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [4:0]    addr = '0;
  logic [N-1:0]  wdata = '0;
  logic [N-1:0]  rdata_a, rdata_b;
  logic [2:0]    irq_a, irq_b;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tirq_ctrl #(.VARIANT(0)) u_tirq_ctrl (
    .clk(clk), .rst(rst), .src_evt_i(src), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata_a), .irq_o(irq_a));

  tirq_ctrl #(.VARIANT(1)) u_tirq_ctrl_b (
    .clk(clk), .rst(rst), .src_evt_i(src), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata_b), .irq_o(irq_b));

  typedef struct packed {
    logic [N-1:0] evt;
    logic [N-1:0] unmask;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{32'h0000_0001, 32'h0000_0001},
    '{32'h0000_0002, 32'hFFFF_FFFF},
    '{32'h0000_0020, 32'h0000_0020},
    '{32'h8000_0000, 32'h8000_0000},
    '{32'h0000_00FF, 32'h0000_0000},
    '{32'h0000_0023, 32'h0000_0021},
    '{32'h0000_0000, 32'hFFFF_FFFF},
    '{32'h0000_000C, 32'h0000_0004}
  };

  function automatic logic [2:0] model_irq(input logic [N-1:0] p, input bit var_b);
    if (var_b) return {1'b0, |(p & ~32'h20), p[5]};
    return {|p[N-1:2], p[1], p[0]};
  endfunction

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [N-1:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [N-1:0] da, output logic [N-1:0] db);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; da = rdata_a; db = rdata_b;
  endtask

  task automatic pulse(input logic [N-1:0] e);
    @(negedge clk); src = e;
    @(negedge clk); src = '0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [N-1:0] ra, rb;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 irqA", {29'b0, irq_a}, 32'h0);
    check("R1 irqB", {29'b0, irq_b}, 32'h0);
    check("R1 rdata", rdata_a, 32'h0);
    bus_read(5'h00, ra, rb); check("R1 flags", ra, 32'h0);
    bus_read(5'h08, ra, rb); check("R1 mask", ra, 32'hFFFF_FFFF);

    // table of vectors: R2 R6 R8 R9 R10
    for (int v = 0; v < 8; v++) begin
      logic [N-1:0] pend;
      bus_write(5'h04, 32'hFFFF_FFFF);
      bus_write(5'h0C, 32'hFFFF_FFFF);
      pulse(VECS[v].evt);
      bus_write(5'h10, VECS[v].unmask);
      settle();
      pend = VECS[v].evt & VECS[v].unmask;
      check("R9 variant A lines", {29'b0, irq_a}, {29'b0, model_irq(pend, 1'b0)});
      check("R10 variant B lines", {29'b0, irq_b}, {29'b0, model_irq(pend, 1'b1)});
      bus_read(5'h00, ra, rb); check("R2 flag readback", ra, VECS[v].evt);
      bus_read(5'h08, ra, rb); check("R6 mask readback", ra, ~VECS[v].unmask);
    end

    // R3 flag-clear: zero bits keep flags
    bus_write(5'h04, 32'hFFFF_FFFF);
    pulse(32'h0000_00F0);
    bus_write(5'h04, 32'h0000_0030);
    bus_read(5'h00, ra, rb); check("R3 partial clear", ra, 32'h0000_00C0);

    // R4 event beats clear on same bit
    @(negedge clk); src = 32'h0000_0008; wr = 1'b1; addr = 5'h04; wdata = 32'h0000_0088;
    @(negedge clk); src = '0; wr = 1'b0; wdata = '0;
    bus_read(5'h00, ra, rb); check("R4 set wins", ra, 32'h0000_0048);

    // R11 level hold, then drop on mask (R5) and on clear
    bus_write(5'h04, 32'hFFFF_FFFF);
    bus_write(5'h10, 32'hFFFF_FFFF);
    pulse(32'h0000_0001);
    repeat (6) @(negedge clk);
    check("R11 line held", {29'b0, irq_a}, 32'h1);
    bus_write(5'h0C, 32'h0000_0001);
    settle();
    check("R5 mask drops line", {29'b0, irq_a}, 32'h0);
    bus_read(5'h08, ra, rb); check("R5 mask bits", ra, 32'h0000_0001);
    bus_write(5'h10, 32'h0000_0001);
    settle();
    check("R11 line back", {29'b0, irq_a}, 32'h1);
    bus_write(5'h04, 32'h0000_0001);
    settle();
    check("R11 clear drops line", {29'b0, irq_a}, 32'h0);

    // R7 write-only and unmapped offsets read 0; unmapped write ignored
    bus_read(5'h04, ra, rb); check("R7 read 0x04", ra, 32'h0);
    bus_read(5'h0C, ra, rb); check("R7 read 0x0C", ra, 32'h0);
    bus_read(5'h10, ra, rb); check("R7 read 0x10", ra, 32'h0);
    bus_read(5'h14, ra, rb); check("R7 read 0x14", ra, 32'h0);
    bus_write(5'h14, 32'hFFFF_FFFF);
    bus_read(5'h08, ra, rb); check("R7 unmapped write", ra, 32'h0000_0000);

    // R7 read returns pre-edge value
    bus_write(5'h04, 32'hFFFF_FFFF);
    @(negedge clk); rd = 1'b1; addr = 5'h00; src = 32'h0000_0100;
    @(negedge clk); rd = 1'b0; src = '0;
    check("R7 pre-edge read", rdata_a, 32'h0);
    bus_read(5'h00, ra, rb); check("R7 later read", ra, 32'h0000_0100);

    // R1 reset mid-run restores defaults
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    bus_read(5'h08, ra, rb); check("R1 mask after reset", rb, 32'hFFFF_FFFF);
    bus_read(5'h00, ra, rb); check("R1 flags after reset", rb, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule